// File: doc/BRIEF.md
# Event Channel Interrupt Pending Unit

This block keeps two interrupt flags for every channel of an event-routing fabric. The first flag records that an event was detected. The second records an overrun. The block picks the most urgent channel that has an enabled flag, and it raises one combined interrupt request. It presents a single 16-bit pending register. That register shows the number of the selected channel, the selected channel's two flags, and the busy and ready state of the users connected to that channel.

Software that serves several channels from one interrupt reads the pending register and takes the channel number from it. It then writes ones to the flag bits to acknowledge them. Each such write clears the matching per-channel flag. Software may also write a channel number with both flag bits at zero. The register then shows that channel's flags and status until the selection is released.

Each channel has the following inputs:
- an event pulse;
- an asynchronous-path mode bit, which suppresses both flags;
- one ready level and one handled level for each connected user;
- an enable bit for each of the two flags.

Top module: `evpend_unit`

## Requirements
- R1: After reset, with every user ready and handled, `rd_data` reads 16'h4000, `irq` is 0 and both flag vectors are all zero.
- R2: `rd_data` bit 15 (busy) is 1 when any handled level of the displayed channel is 0. Bit 14 (ready) is 1 when every ready level of that channel is 1. Bits 13:10 and 7:4 read 0.
- R3: An event pulse on a channel in synchronous mode sets that channel's event flag at the next clock edge. `rd_data` bit 9 shows the event flag of the displayed channel.
- R4: An event pulse on a synchronous channel sets its overrun flag at the next edge when, in that cycle, any of the channel's users is not ready or has not handled. `rd_data` bit 8 shows the overrun flag of the displayed channel.
- R5: A channel in asynchronous mode (`async_mode` bit = 1) never sets either of its flags.
- R6: A write with `wr_clr_evd` = 1 clears the event flag of channel `wr_id`. A write with `wr_clr_ovr` = 1 clears the overrun flag of channel `wr_id`. A write that has a flag bit at 0 leaves that flag unchanged.
- R7: When an event sets a flag in the same cycle as a write clears that flag, the flag ends up set.
- R8: While no selection is held, the ID field in `rd_data` bits 3:0 is the lowest-numbered channel that has an enabled flag set. If no channel has one, the ID field is 0.
- R9: A write with both clear bits at 0 holds `wr_id` as the displayed channel. While the hold lasts, bits 15, 14, 9 and 8 reflect that channel.
- R10: A held selection is released by any write that has a clear bit at 1. It is also released by an enabled flag being newly set on a channel numbered below the held one.
- R11: `irq` is 1 exactly when some channel has a flag set together with that flag's enable. A flag whose enable is 0 affects neither `irq` nor the ID choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_pulse | input | NCH | One-cycle event pulse per channel |
| async_mode | input | NCH | 1 = channel path is asynchronous, flags suppressed |
| usr_ready | input | NCH*NUSR | Ready level per user, channel c at bits c*NUSR+:NUSR |
| usr_handled | input | NCH*NUSR | Handled level per user, same packing |
| en_evd | input | NCH | Event-flag interrupt enable per channel |
| en_ovr | input | NCH | Overrun-flag interrupt enable per channel |
| wr_en | input | 1 | Write strobe to the pending register |
| wr_clr_evd | input | 1 | Written value of bit 9 (1 = clear event flag) |
| wr_clr_ovr | input | 1 | Written value of bit 8 (1 = clear overrun flag) |
| wr_id | input | 4 | Written value of bits 3:0 (channel number) |
| rd_data | output | 16 | Pending register read value |
| irq | output | 1 | Combined interrupt request |
| evd_flags | output | NCH | Event flag per channel |
| ovr_flags | output | NCH | Overrun flag per channel |

## Verification
The properties expect `ev_pulse`, `async_mode` and the user ready and handled levels to be stable around the clock edge. They also expect `wr_id` to name an existing channel, because the clear and hold rules index the channel by that field. The stimulus drives every input on the falling edge and keeps `wr_id` below NCH. It holds `async_mode` constant while a channel is being pulsed. It changes the user levels only between events, so that each overrun cause is applied on its own.

// File: rtl/evpend_pkg.sv
// Shared constants for the pending unit: field positions of the 16-bit pending
// register. Software decodes these positions, so they are fixed here.
package evpend_pkg;
    localparam int REG_W    = 16;
    localparam int ID_W     = 4;
    localparam int BIT_BUSY = 15;
    localparam int BIT_RDY  = 14;
    localparam int BIT_EVD  = 9;
    localparam int BIT_OVR  = 8;
endpackage

// File: rtl/evpend_flag_bank.sv
// Per-channel flag storage. For every channel it keeps an event flag and an
// overrun flag, and it reduces the per-user ready and handled levels.
// Assumes the inputs are synchronous to clk. A set beats a clear in the same cycle.
module evpend_flag_bank #(
    parameter int NCH  = 16,
    parameter int NUSR = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       ev_pulse,
    input  logic [NCH-1:0]       async_mode,
    input  logic [NCH*NUSR-1:0]  usr_ready,
    input  logic [NCH*NUSR-1:0]  usr_handled,
    input  logic [NCH-1:0]       clr_evd,
    input  logic [NCH-1:0]       clr_ovr,
    output logic [NCH-1:0]       evd_q,
    output logic [NCH-1:0]       ovr_q,
    output logic [NCH-1:0]       evd_set,
    output logic [NCH-1:0]       ovr_set,
    output logic [NCH-1:0]       all_ready,
    output logic [NCH-1:0]       all_handled
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Reduce this channel's user levels and decide the set conditions.
        always_comb begin
            all_ready[c]   = &usr_ready[c*NUSR +: NUSR];
            all_handled[c] = &usr_handled[c*NUSR +: NUSR];
            evd_set[c]     = ev_pulse[c] & ~async_mode[c];
            ovr_set[c]     = evd_set[c] & ~(all_ready[c] & all_handled[c]);
        end

        // Flag registers: a set has priority over a clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                evd_q[c] <= 1'b0;
                ovr_q[c] <= 1'b0;
            end else begin
                evd_q[c] <= evd_set[c] | (evd_q[c] & ~clr_evd[c]);
                ovr_q[c] <= ovr_set[c] | (ovr_q[c] & ~clr_ovr[c]);
            end
        end
    end
endmodule

// File: rtl/evpend_prio_pick.sv
// Fixed-priority picker: the lowest channel number wins. The index is 0 when
// nothing is pending. Assumes NCH <= 2**ID_W.
module evpend_prio_pick
    import evpend_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic [NCH-1:0]  pend,
    output logic            any,
    output logic [ID_W-1:0] idx
);
    // Scan from the top so that the lowest set channel is the last one assigned.
    always_comb begin
        any = |pend;
        idx = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (pend[c]) idx = ID_W'(c);
        end
    end
endmodule

// File: rtl/evpend_id_ctrl.sv
// Channel selection for the pending register. A write with both clear bits at 0
// holds the written channel. A write with any clear bit at 1 releases the hold,
// and so does a new enabled set on a lower-numbered channel.
// While the selection is free, the picker result is shown.
module evpend_id_ctrl
    import evpend_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_clr,
    input  logic [ID_W-1:0] wr_id,
    input  logic [NCH-1:0]  set_en,
    input  logic [ID_W-1:0] winner,
    output logic [ID_W-1:0] id_sel,
    output logic            locked
);
    logic [ID_W-1:0] id_q;
    logic            new_hi;

    // Detect an enabled set on a channel numbered below the held one.
    always_comb begin
        new_hi = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (set_en[c] && (ID_W'(c) < id_q)) new_hi = 1'b1;
        end
    end

    // Hold state: a write takes priority over release by a new set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            id_q   <= '0;
        end else if (wr_en) begin
            locked <= ~wr_clr;
            if (!wr_clr) id_q <= wr_id;
        end else if (locked && new_hi) begin
            locked <= 1'b0;
        end
    end

    // Displayed channel: the held channel while locked, otherwise the picker result.
    always_comb id_sel = locked ? id_q : winner;
endmodule

// File: rtl/evpend_unit.sv
// Top of the pending unit. It joins the flag bank, the picker and the selection
// control, and it builds the 16-bit pending register read value.
// Assumes NCH <= 16 and that wr_id names an existing channel.
module evpend_unit
    import evpend_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int NUSR = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       ev_pulse,
    input  logic [NCH-1:0]       async_mode,
    input  logic [NCH*NUSR-1:0]  usr_ready,
    input  logic [NCH*NUSR-1:0]  usr_handled,
    input  logic [NCH-1:0]       en_evd,
    input  logic [NCH-1:0]       en_ovr,
    input  logic                 wr_en,
    input  logic                 wr_clr_evd,
    input  logic                 wr_clr_ovr,
    input  logic [ID_W-1:0]      wr_id,
    output logic [REG_W-1:0]     rd_data,
    output logic                 irq,
    output logic [NCH-1:0]       evd_flags,
    output logic [NCH-1:0]       ovr_flags
);
    logic [NCH-1:0]  clr_evd, clr_ovr;
    logic [NCH-1:0]  evd_set, ovr_set, all_ready, all_handled;
    logic [NCH-1:0]  pend, set_en;
    logic [ID_W-1:0] winner, id_sel;
    logic            any_pend, lock_q;

    // Turn a clear write into a one-hot clear of the addressed channel.
    always_comb begin
        clr_evd = '0;
        clr_ovr = '0;
        for (int c = 0; c < NCH; c++) begin
            if (wr_en && wr_id == ID_W'(c)) begin
                clr_evd[c] = wr_clr_evd;
                clr_ovr[c] = wr_clr_ovr;
            end
        end
    end

    evpend_flag_bank #(.NCH(NCH), .NUSR(NUSR)) bank_i (
        .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .async_mode(async_mode),
        .usr_ready(usr_ready), .usr_handled(usr_handled),
        .clr_evd(clr_evd), .clr_ovr(clr_ovr),
        .evd_q(evd_flags), .ovr_q(ovr_flags),
        .evd_set(evd_set), .ovr_set(ovr_set),
        .all_ready(all_ready), .all_handled(all_handled)
    );

    // Enabled pending flags, and enabled flags being set in this cycle.
    always_comb begin
        pend   = (evd_flags & en_evd) | (ovr_flags & en_ovr);
        set_en = (evd_set & en_evd) | (ovr_set & en_ovr);
    end

    evpend_prio_pick #(.NCH(NCH)) pick_i (
        .pend(pend), .any(any_pend), .idx(winner)
    );

    evpend_id_ctrl #(.NCH(NCH)) idc_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_clr(wr_clr_evd | wr_clr_ovr), .wr_id(wr_id),
        .set_en(set_en), .winner(winner), .id_sel(id_sel), .locked(lock_q)
    );

    // Combined request and the read value of the pending register.
    always_comb begin
        irq               = any_pend;
        rd_data           = '0;
        rd_data[BIT_BUSY] = ~all_handled[id_sel];
        rd_data[BIT_RDY]  = all_ready[id_sel];
        rd_data[BIT_EVD]  = evd_flags[id_sel];
        rd_data[BIT_OVR]  = ovr_flags[id_sel];
        rd_data[ID_W-1:0] = id_sel;
    end
endmodule

// File: rtl/evpend_unit_chk.sv
// Property checker for evpend_unit. It is attached through bind and observes the
// ports and the selection-hold state.
module evpend_unit_chk
    import evpend_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int NUSR = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NCH-1:0]      ev_pulse,
    input logic [NCH-1:0]      async_mode,
    input logic [NCH*NUSR-1:0] usr_ready,
    input logic [NCH*NUSR-1:0] usr_handled,
    input logic [NCH-1:0]      en_evd,
    input logic [NCH-1:0]      en_ovr,
    input logic                wr_en,
    input logic                wr_clr_evd,
    input logic                wr_clr_ovr,
    input logic [ID_W-1:0]     wr_id,
    input logic [REG_W-1:0]    rd_data,
    input logic                irq,
    input logic [NCH-1:0]      evd_flags,
    input logic [NCH-1:0]      ovr_flags,
    input logic                locked
);
    // R3: an event on a synchronous channel leaves its event flag set.
    p_evd_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_pulse & ~async_mode) != '0) |=>
        ((evd_flags & $past(ev_pulse & ~async_mode)) == $past(ev_pulse & ~async_mode)));

    // R5: an asynchronous channel never gains a flag.
    p_async_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (async_mode != '0) |=>
        ((((evd_flags & ~$past(evd_flags)) | (ovr_flags & ~$past(ovr_flags)))
          & $past(async_mode)) == '0));

    // R8: with no hold, a raised irq means the shown channel has an enabled flag.
    p_id_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !locked) |->
        ((rd_data[BIT_EVD] && en_evd[rd_data[ID_W-1:0]]) ||
         (rd_data[BIT_OVR] && en_ovr[rd_data[ID_W-1:0]])));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // R4: an event that meets a not-ready or not-handled user sets the overrun flag.
        p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_pulse[c] && !async_mode[c] &&
             (!(&usr_ready[c*NUSR +: NUSR]) || !(&usr_handled[c*NUSR +: NUSR])))
            |=> ovr_flags[c]);

        // R6: a clear write with no competing set empties the addressed flag.
        p_clr_evd_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_clr_evd && wr_id == ID_W'(c) && !(ev_pulse[c] && !async_mode[c]))
            |=> !evd_flags[c]);
        p_clr_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_clr_ovr && wr_id == ID_W'(c) && !(ev_pulse[c] && !async_mode[c]))
            |=> !ovr_flags[c]);

        // R7: a set that meets a clear in the same cycle wins.
        p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_clr_evd && wr_id == ID_W'(c) && ev_pulse[c] && !async_mode[c])
            |=> evd_flags[c]);
    end
endmodule

bind evpend_unit evpend_unit_chk #(.NCH(NCH), .NUSR(NUSR)) chk_i (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .async_mode(async_mode),
    .usr_ready(usr_ready), .usr_handled(usr_handled), .en_evd(en_evd),
    .en_ovr(en_ovr), .wr_en(wr_en), .wr_clr_evd(wr_clr_evd),
    .wr_clr_ovr(wr_clr_ovr), .wr_id(wr_id), .rd_data(rd_data), .irq(irq),
    .evd_flags(evd_flags), .ovr_flags(ovr_flags), .locked(lock_q)
);

// File: tb/evpend_unit_tb_top.sv
// Directed bench for evpend_unit. Each scenario is a task that checks its own results.
module evpend_unit_tb_top;
    localparam int NCH  = 16;
    localparam int NUSR = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NCH-1:0]      ev_pulse = '0, async_mode = '0, en_evd = '0, en_ovr = '0;
    logic [NCH*NUSR-1:0] usr_ready = '1, usr_handled = '1;
    logic                wr_en = 1'b0, wr_clr_evd = 1'b0, wr_clr_ovr = 1'b0;
    logic [3:0]          wr_id = '0;
    logic [15:0]         rd_data;
    logic                irq;
    logic [NCH-1:0]      evd_flags, ovr_flags;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    evpend_unit #(.NCH(NCH), .NUSR(NUSR)) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .async_mode(async_mode),
        .usr_ready(usr_ready), .usr_handled(usr_handled), .en_evd(en_evd),
        .en_ovr(en_ovr), .wr_en(wr_en), .wr_clr_evd(wr_clr_evd),
        .wr_clr_ovr(wr_clr_ovr), .wr_id(wr_id), .rd_data(rd_data), .irq(irq),
        .evd_flags(evd_flags), .ovr_flags(ovr_flags)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Pulse the channels in mask for one cycle. The flags are visible on return.
    task automatic pulse(logic [NCH-1:0] mask);
        @(negedge clk); ev_pulse = mask;
        @(negedge clk); ev_pulse = '0;
    endtask

    // One write to the pending register. Its effect is visible on return.
    task automatic wr(bit ce, bit co, logic [3:0] id);
        @(negedge clk); wr_en = 1'b1; wr_clr_evd = ce; wr_clr_ovr = co; wr_id = id;
        @(negedge clk); wr_en = 1'b0; wr_clr_evd = 1'b0; wr_clr_ovr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rd_data", 32'(rd_data), 32'h4000);
        check("R1 irq", 32'(irq), 0);
        check("R1 flags", {evd_flags, ovr_flags}, 0);
    endtask

    task automatic t_event_clear();
        en_evd[5] = 1'b1;
        pulse(16'h0020);
        check("R3 evd_flags", 32'(evd_flags), 32'h0020);
        check("R8 rd_data ch5", 32'(rd_data), 32'h4205);
        check("R11 irq", 32'(irq), 1);
        wr(1'b0, 1'b0, 4'd5);
        check("R6 zero write keeps flag", 32'(evd_flags), 32'h0020);
        check("R9 hold ch5", 32'(rd_data), 32'h4205);
        wr(1'b1, 1'b0, 4'd5);
        check("R6 cleared", 32'(evd_flags), 0);
        check("R6 rd_data", 32'(rd_data), 32'h4000);
        check("R11 irq low", 32'(irq), 0);
        en_evd[5] = 1'b0;
    endtask

    task automatic t_overrun();
        en_evd[3] = 1'b1; en_ovr[3] = 1'b1;
        usr_ready[3*NUSR+1] = 1'b0;
        pulse(16'h0008);
        check("R4 ovr not ready", 32'(ovr_flags), 32'h0008);
        check("R2 ready low", 32'(rd_data), 32'h0303);
        usr_ready[3*NUSR+1] = 1'b1;
        usr_handled[3*NUSR] = 1'b0;
        @(negedge clk);
        check("R2 busy high", 32'(rd_data), 32'hC303);
        wr(1'b0, 1'b1, 4'd3);
        check("R6 ovr cleared only", 32'(rd_data), 32'hC203);
        pulse(16'h0008);
        check("R4 ovr not handled", 32'(rd_data), 32'hC303);
        usr_handled[3*NUSR] = 1'b1;
        wr(1'b1, 1'b1, 4'd3);
        check("R6 both cleared", 32'(rd_data), 32'h4000);
        en_evd[3] = 1'b0; en_ovr[3] = 1'b0;
    endtask

    task automatic t_async();
        async_mode[7] = 1'b1; en_evd[7] = 1'b1; en_ovr[7] = 1'b1;
        usr_ready[7*NUSR] = 1'b0;
        pulse(16'h0080);
        check("R5 no flags", {evd_flags, ovr_flags}, 0);
        check("R5 irq", 32'(irq), 0);
        usr_ready[7*NUSR] = 1'b1;
        async_mode[7] = 1'b0; en_evd[7] = 1'b0; en_ovr[7] = 1'b0;
    endtask

    task automatic t_priority();
        en_evd = 16'hFFFD;                  // channel 1 disabled
        pulse(16'h0204);                    // channels 2 and 9
        check("R8 lowest wins", 32'(rd_data), 32'h4202);
        pulse(16'h0002);                    // channel 1, enable off
        check("R11 disabled flag stored", 32'(evd_flags), 32'h0206);
        check("R11 disabled ignored for ID", 32'(rd_data), 32'h4202);
        wr(1'b0, 1'b0, 4'd9);
        check("R9 hold ch9", 32'(rd_data), 32'h4209);
        pulse(16'h1000);                    // channel 12: lower priority
        check("R10 hold kept", 32'(rd_data), 32'h4209);
        pulse(16'h0010);                    // channel 4: above the held channel
        check("R10 released by new set", 32'(rd_data), 32'h4202);
        wr(1'b0, 1'b0, 4'd9);
        wr(1'b1, 1'b0, 4'd9);
        check("R10 released by clear", 32'(rd_data), 32'h4202);
        wr(1'b1, 1'b0, 4'd2);
        wr(1'b1, 1'b0, 4'd4);
        wr(1'b1, 1'b0, 4'd12);
        wr(1'b1, 1'b0, 4'd1);
        check("R6 all cleared", 32'(evd_flags), 0);
        check("R11 irq low", 32'(irq), 0);
        en_evd = '0;
    endtask

    task automatic t_set_wins();
        en_evd[6] = 1'b1;
        pulse(16'h0040);
        @(negedge clk);
        ev_pulse = 16'h0040; wr_en = 1'b1; wr_clr_evd = 1'b1; wr_id = 4'd6;
        @(negedge clk);
        ev_pulse = '0; wr_en = 1'b0; wr_clr_evd = 1'b0;
        check("R7 set beats clear", 32'(evd_flags), 32'h0040);
        wr(1'b1, 1'b0, 4'd6);
        check("R7 later clear", 32'(evd_flags), 0);
        en_evd[6] = 1'b0;
    endtask

    task automatic t_enable_gate();
        pulse(16'h0001);
        check("R11 irq gated", 32'(irq), 0);
        check("R8 default id", 32'(rd_data), 32'h4200);
        en_evd[0] = 1'b1;
        #1;
        check("R11 enable raises irq", 32'(irq), 1);
        wr(1'b1, 1'b0, 4'd0);
        check("R11 cleared", 32'(irq), 0);
        en_evd[0] = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_event_clear();
        t_overrun();
        t_async();
        t_priority();
        t_set_wins();
        t_enable_gate();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule